// File: doc/BRIEF.md
# Write-Miss Invalidation Collector

This block sits beside a processor in a distributed shared-memory node and handles a write miss from start to finish. When the processor misses on a write, the block takes the block address and picks the home node from the top bits of that address. It then sends a write request to the home node. If the home is the local node, no request goes out, and the block waits for the local directory's reply instead. The processor stays stalled from the cycle after the miss is taken until the block is filled.

A clean reply from the home carries the data and a vector of the nodes that hold copies. The block sends one invalidation to each listed node except itself. It issues at most one invalidation per cycle and walks the node IDs from low to high. It loads a counter with the number of invalidations sent and decrements the counter on each acknowledgement. The block is written into the local cache in the modified state only once the counter reaches zero.

A reply that comes directly from the previous owner of a dirty block needs no fan-out, so that block is filled at once. A refusal from the home makes the block wait a fixed number of cycles and then send the request again.

Top module: `wmiss_collector`

## Requirements
- R1: While reset is held, and in the first cycle after it, `stall`, `outValid` and `fillValid` are all 0.
- R2: The home node ID is the top NODE_W bits of the miss address. In the cycle after a miss is accepted, `stall` is 1. For a remote home, that same cycle carries a write request: `outType`=0, `outDest`=home, `outAddr`=the miss address.
- R3: When the home ID equals LOCAL_ID, no write request is sent. The block goes straight to waiting for the reply.
- R4: A home-data reply (`inType`=0) starts the fan-out. The set to invalidate is `inVec` with bit LOCAL_ID cleared. One invalidation (`outType`=1) goes to each node in that set, one per cycle, in rising node-ID order, with no gaps between them.
- R5: `stall` stays 1 and `fillValid` stays 0 until one acknowledgement (`inType`=3) has arrived for every invalidation sent. After that, `fillValid` pulses for one cycle with the miss address and the reply data, meaning the block is installed as modified. `stall` is 0 in the cycle after the fill.
- R6: If the set to invalidate is empty once LOCAL_ID is removed, the block fills without sending any invalidation.
- R7: An owner-data reply (`inType`=1) fills the block with its data and sends no invalidation, whatever `inVec` holds.
- R8: A refusal (`inType`=2) sends no message for BACKOFF+1 cycles after the refusal is taken. In the cycle after that, the write request to the same home is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Processor write miss request |
| missAddr | input | ADDR_W | Block address of the miss |
| stall | output | 1 | Processor held while a miss is in flight |
| outValid | output | 1 | Outgoing message valid |
| outType | output | 1 | 0 write request, 1 invalidation |
| outDest | output | NODE_W | Destination node of the outgoing message |
| outAddr | output | ADDR_W | Block address carried by the outgoing message |
| inValid | input | 1 | Incoming message valid |
| inType | input | 2 | 0 home data, 1 owner data, 2 refusal, 3 acknowledgement |
| inData | input | DATA_W | Block data of a data reply |
| inVec | input | NODES | Presence vector of a home-data reply |
| fillValid | output | 1 | Install the block in the cache as modified |
| fillAddr | output | ADDR_W | Address of the block being filled |
| fillData | output | DATA_W | Data of the block being filled |

## Verification
The assertions hold on every cycle for the following rules:
- a fill only happens while the processor is stalled, and the stall drops right after the fill;
- no message is ever addressed to the local node;
- invalidations in a burst rise strictly in node ID;
- an accepted miss raises the stall at once.

Some properties need whole transactions, so only the bench's scenarios show them:
- that the set of invalidated nodes matches the returned vector;
- that the fill waits for exactly as many acknowledgements as there were sharers;
- that the fill data comes from the right reply;
- that the resend after a refusal keeps its exact timing.

// File: rtl/wmiss_pkg.sv
package wmiss_pkg;

  typedef enum logic [1:0] {
    MSG_HOME_DATA  = 2'd0,
    MSG_OWNER_DATA = 2'd1,
    MSG_REFUSE     = 2'd2,
    MSG_ACK        = 2'd3
  } inMsg_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT_HOME, ST_BACKOFF, ST_INVAL, ST_WAIT_ACK, ST_FILL
  } reqState_e;

  typedef struct packed {
    logic captureAddr;
    logic loadReply;
    logic loadOwner;
    logic popInval;
    logic ackTake;
    logic startBackoff;
    logic tickBackoff;
  } reqStrobe_t;

endpackage

// File: rtl/wmiss_datapath.sv
module wmiss_datapath
  import wmiss_pkg::*;
#(
  parameter int NODES    = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int LOCAL_ID = 2,
  parameter int BACKOFF  = 3,
  localparam int NODE_W  = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  reqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [NODES-1:0]  inVec,
  output logic [NODE_W-1:0] homeId,
  output logic              homeLocal,
  output logic              missHomeLocal,
  output logic [NODE_W-1:0] lowestId,
  output logic              lastInval,
  output logic              replyEmpty,
  output logic              ackZero,
  output logic              backoffZero,
  output logic [ADDR_W-1:0] blkAddr,
  output logic [DATA_W-1:0] blkData
);
  localparam int CNT_W = $clog2(NODES + 1);
  localparam int BO_W  = $clog2(BACKOFF + 1);
  localparam logic [NODE_W-1:0] LOCAL_NODE = NODE_W'(LOCAL_ID);

  logic [NODES-1:0] pending;
  logic [NODES-1:0] masked;
  logic [CNT_W-1:0] maskCount;
  logic [CNT_W-1:0] ackCnt;
  logic [BO_W-1:0]  backoffCnt;

  assign masked = inVec & ~(NODES'(1) << LOCAL_ID);

  always_comb begin
    maskCount = '0;
    for (int i = 0; i < NODES; i++) maskCount = maskCount + CNT_W'(masked[i]);
  end

  always_comb begin
    lowestId = '0;
    for (int i = NODES - 1; i >= 0; i--) if (pending[i]) lowestId = NODE_W'(i);
  end

  assign homeId        = blkAddr[ADDR_W-1 -: NODE_W];
  assign homeLocal     = (homeId == LOCAL_NODE);
  assign missHomeLocal = (missAddr[ADDR_W-1 -: NODE_W] == LOCAL_NODE);
  assign lastInval     = ((pending & (pending - NODES'(1))) == '0);
  assign replyEmpty    = (masked == '0);
  assign ackZero       = (ackCnt == '0);
  assign backoffZero   = (backoffCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkAddr    <= '0;
      blkData    <= '0;
      pending    <= '0;
      ackCnt     <= '0;
      backoffCnt <= '0;
    end else begin
      if (strobe.captureAddr) blkAddr <= missAddr;
      if (strobe.loadReply || strobe.loadOwner) blkData <= inData;
      if (strobe.loadReply) pending <= masked;
      else if (strobe.popInval) pending <= pending & (pending - NODES'(1));
      if (strobe.loadReply) ackCnt <= maskCount;
      else if (strobe.ackTake && ackCnt != '0) ackCnt <= ackCnt - CNT_W'(1);
      if (strobe.startBackoff) backoffCnt <= BO_W'(BACKOFF);
      else if (strobe.tickBackoff) backoffCnt <= backoffCnt - BO_W'(1);
    end
  end

endmodule

// File: rtl/wmiss_control.sv
module wmiss_control
  import wmiss_pkg::*;
#(
  parameter int NODES   = 8,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic              inValid,
  input  logic [1:0]        inType,
  input  logic [NODE_W-1:0] homeId,
  input  logic              homeLocal,
  input  logic              missHomeLocal,
  input  logic [NODE_W-1:0] lowestId,
  input  logic              lastInval,
  input  logic              replyEmpty,
  input  logic              ackZero,
  input  logic              backoffZero,
  output reqStrobe_t        strobe,
  output logic              stall,
  output logic              outValid,
  output logic              outType,
  output logic [NODE_W-1:0] outDest,
  output logic              fillValid
);
  reqState_e state, nextState;
  inMsg_e    msg;

  assign msg = inMsg_e'(inType);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (missValid) begin
        strobe.captureAddr = 1'b1;
        nextState = missHomeLocal ? ST_WAIT_HOME : ST_REQ;
      end
      ST_REQ: nextState = ST_WAIT_HOME;
      ST_WAIT_HOME: if (inValid) begin
        unique case (msg)
          MSG_HOME_DATA: begin
            strobe.loadReply = 1'b1;
            nextState = replyEmpty ? ST_FILL : ST_INVAL;
          end
          MSG_OWNER_DATA: begin
            strobe.loadOwner = 1'b1;
            nextState = ST_FILL;
          end
          MSG_REFUSE: begin
            strobe.startBackoff = 1'b1;
            nextState = ST_BACKOFF;
          end
          default: ;
        endcase
      end
      ST_BACKOFF: begin
        if (backoffZero) nextState = homeLocal ? ST_WAIT_HOME : ST_REQ;
        else strobe.tickBackoff = 1'b1;
      end
      ST_INVAL: begin
        strobe.popInval = 1'b1;
        strobe.ackTake  = inValid && msg == MSG_ACK;
        if (lastInval) nextState = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        strobe.ackTake = inValid && msg == MSG_ACK;
        if (ackZero) nextState = ST_FILL;
      end
      ST_FILL: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign stall     = (state != ST_IDLE);
  assign outValid  = (state == ST_REQ) || (state == ST_INVAL);
  assign outType   = (state == ST_INVAL);
  assign outDest   = (state == ST_INVAL) ? lowestId : homeId;
  assign fillValid = (state == ST_FILL);

endmodule

// File: rtl/wmiss_collector.sv
module wmiss_collector
  import wmiss_pkg::*;
#(
  parameter int NODES    = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int LOCAL_ID = 2,
  parameter int BACKOFF  = 3,
  localparam int NODE_W  = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              stall,
  output logic              outValid,
  output logic              outType,
  output logic [NODE_W-1:0] outDest,
  output logic [ADDR_W-1:0] outAddr,
  input  logic              inValid,
  input  logic [1:0]        inType,
  input  logic [DATA_W-1:0] inData,
  input  logic [NODES-1:0]  inVec,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [DATA_W-1:0] fillData
);
  reqStrobe_t        strobe;
  logic [NODE_W-1:0] homeId, lowestId;
  logic              homeLocal, missHomeLocal, lastInval, replyEmpty, ackZero, backoffZero;
  logic [ADDR_W-1:0] blkAddr;
  logic [DATA_W-1:0] blkData;

  wmiss_datapath #(
    .NODES(NODES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCAL_ID(LOCAL_ID), .BACKOFF(BACKOFF)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .missAddr(missAddr), .inData(inData),
    .inVec(inVec), .homeId(homeId), .homeLocal(homeLocal), .missHomeLocal(missHomeLocal),
    .lowestId(lowestId), .lastInval(lastInval), .replyEmpty(replyEmpty), .ackZero(ackZero),
    .backoffZero(backoffZero), .blkAddr(blkAddr), .blkData(blkData)
  );

  wmiss_control #(.NODES(NODES)) control_i (
    .clk(clk), .rstN(rstN), .missValid(missValid), .inValid(inValid), .inType(inType),
    .homeId(homeId), .homeLocal(homeLocal), .missHomeLocal(missHomeLocal),
    .lowestId(lowestId), .lastInval(lastInval), .replyEmpty(replyEmpty), .ackZero(ackZero),
    .backoffZero(backoffZero), .strobe(strobe), .stall(stall), .outValid(outValid),
    .outType(outType), .outDest(outDest), .fillValid(fillValid)
  );

  assign outAddr  = blkAddr;
  assign fillAddr = blkAddr;
  assign fillData = blkData;

endmodule

// File: rtl/wmiss_checker.sv
module wmiss_checker #(
  parameter int NODES    = 8,
  parameter int LOCAL_ID = 2,
  localparam int NODE_W  = $clog2(NODES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              stall,
  input logic              outValid,
  input logic              outType,
  input logic [NODE_W-1:0] outDest,
  input logic              fillValid
);
  localparam logic [NODE_W-1:0] LOCAL_NODE = NODE_W'(LOCAL_ID);

  assert_accept_stalls_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && missValid) |=> stall);

  assert_no_local_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outType) |-> outDest != LOCAL_NODE);

  assert_no_self_inval_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType) |-> outDest != LOCAL_NODE);

  assert_inval_ascending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType && $past(outValid && outType)) |-> outDest > $past(outDest));

  assert_fill_while_stalled_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> stall);

  assert_release_after_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> !stall);

endmodule

bind wmiss_collector wmiss_checker #(.NODES(NODES), .LOCAL_ID(LOCAL_ID)) checker_i (
  .clk(clk), .rstN(rstN), .missValid(missValid), .stall(stall), .outValid(outValid),
  .outType(outType), .outDest(outDest), .fillValid(fillValid)
);

// File: tb/wmiss_collector_tb.sv
module wmiss_collector_tb_top;
  localparam int NODES = 8, ADDR_W = 12, DATA_W = 16, LOCAL_ID = 2, BACKOFF = 3;
  localparam int NODE_W = $clog2(NODES);
  localparam int NVEC = 5;

  // Stimulus table: address, presence vector, data, expected invalidation set
  localparam logic [ADDR_W-1:0] V_ADDR [NVEC] = '{12'hA34, 12'h234, 12'h4F0, 12'hE00, 12'hF12};
  localparam logic [NODES-1:0]  V_VEC  [NVEC] = '{8'h23, 8'h86, 8'h10, 8'h04, 8'hFF};
  localparam logic [DATA_W-1:0] V_DATA [NVEC] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555};
  localparam logic [NODES-1:0]  V_EXP  [NVEC] = '{8'h23, 8'h82, 8'h10, 8'h00, 8'hFB};

  logic clk = 0, rstN = 0;
  logic missValid = 0;
  logic [ADDR_W-1:0] missAddr = '0;
  logic stall, outValid, outType, fillValid;
  logic [NODE_W-1:0] outDest;
  logic [ADDR_W-1:0] outAddr, fillAddr;
  logic inValid = 0;
  logic [1:0] inType = '0;
  logic [DATA_W-1:0] inData = '0, fillData;
  logic [NODES-1:0] inVec = '0;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  wmiss_collector dut_i (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr), .stall(stall),
    .outValid(outValid), .outType(outType), .outDest(outDest), .outAddr(outAddr),
    .inValid(inValid), .inType(inType), .inData(inData), .inVec(inVec),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendMsg(input logic [1:0] t, input logic [NODES-1:0] v, input logic [DATA_W-1:0] d);
    inValid = 1; inType = t; inVec = v; inData = d;
    @(negedge clk);
    inValid = 0; inVec = '0;
  endtask

  // Accept a miss and check the request cycle (R2/R3); leaves state waiting for reply
  task automatic startMiss(input logic [ADDR_W-1:0] a);
    logic [NODE_W-1:0] home = a[ADDR_W-1 -: NODE_W];
    missValid = 1; missAddr = a;
    @(negedge clk);
    missValid = 0;
    check(stall === 1'b1, "R2 stall", 32'(stall), 1);
    if (home == NODE_W'(LOCAL_ID))
      check(outValid === 1'b0, "R3 no request", 32'(outValid), 0);
    else
      check(outValid && !outType && outDest == home && outAddr == a, "R2 request",
            {outValid, outType, 14'(outDest), 16'(outAddr)}, {2'b10, 14'(home), 16'(a)});
    if (home != NODE_W'(LOCAL_ID)) @(negedge clk);
  endtask

  task automatic finishFill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string req);
    int n = 0;
    while (!fillValid && n < 5) begin @(negedge clk); n++; end
    check(fillValid && fillAddr == a && fillData == d, req,
          {fillValid, 15'(fillAddr), fillData}, {1'b1, 15'(a), d});
    @(negedge clk);
    check(stall === 1'b0, "R5 stall release", 32'(stall), 0);
  endtask

  task automatic runHome(input logic [ADDR_W-1:0] a, input logic [NODES-1:0] v,
                         input logic [DATA_W-1:0] d, input logic [NODES-1:0] expSet);
    logic [NODES-1:0] seen = '0;
    int last = -1, cnt = 0;
    bit ordered = 1;
    startMiss(a);
    sendMsg(2'd0, v, d);
    while (outValid && outType && cnt < NODES) begin
      if (int'(outDest) <= last) ordered = 0;
      last = int'(outDest);
      seen[outDest] = 1'b1;
      cnt++;
      @(negedge clk);
    end
    check(seen == expSet, "R4 invalidation set", 32'(seen), 32'(expSet));
    check(ordered, "R4 ascending order", 32'(ordered), 1);
    if (expSet == '0) check(cnt == 0, "R6 no fan-out", cnt, 0);
    for (int i = 0; i < $countones(expSet); i++) begin
      check(stall && !fillValid, "R5 hold before last ack", {stall, fillValid}, 2'b10);
      sendMsg(2'd3, '0, '0);
    end
    finishFill(a, d, "R5 fill after acks");
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(!stall && !outValid && !fillValid, "R1 during reset", {stall, outValid, fillValid}, 0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!stall && !outValid && !fillValid, "R1 after reset", {stall, outValid, fillValid}, 0);

    for (int k = 0; k < NVEC; k++) runHome(V_ADDR[k], V_VEC[k], V_DATA[k], V_EXP[k]);

    // R7: owner data reply, vector must be ignored
    startMiss(12'h6A0);
    sendMsg(2'd1, 8'hFF, 16'hBEEF);
    check(!(outValid && outType), "R7 no invalidation", {outValid, outType}, 0);
    finishFill(12'h6A0, 16'hBEEF, "R7 owner fill");

    // R8: refusal then backoff then resend
    startMiss(12'hC10);
    sendMsg(2'd2, '0, '0);
    for (int k = 1; k <= BACKOFF + 1; k++) begin
      check(outValid === 1'b0, "R8 silent backoff", 32'(outValid), 0);
      @(negedge clk);
    end
    check(outValid && !outType && outDest == 3'd6 && outAddr == 12'hC10, "R8 resend",
          {outValid, outType, 14'(outDest)}, {2'b10, 14'd6});
    @(negedge clk);
    sendMsg(2'd1, '0, 16'h0A0A);
    finishFill(12'hC10, 16'h0A0A, "R8 fill after resend");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule